// File: doc/BRIEF.md
# Page Write Load Controller

This block is the device-side control logic of a byte-alterable nonvolatile memory. It watches three active-low strobes (chip select, write strobe, read strobe), an address bus and a data bus. It gathers byte loads that belong to one 128-byte page into a staging buffer. When the host stops loading for a programmable number of clock cycles, the page is closed. A timed programming interval then follows, during which the buffered bytes are copied into the storage array and the block reports itself busy.

The strobes arrive from outside the clock domain. They are synchronised and their edges are found in the clock domain. A load cycle opens when chip select and write strobe are both low while the read strobe is high. The address is taken when that condition begins, which is at the later of the two falling edges. The data is taken when the condition ends, which is at the earlier of the two rising edges. The window and the programming time are counted in clock cycles. The array is a plain synchronous RAM whose depth follows the address width parameter. A full 15-bit part uses `ADDR_W = 15`, and the default is smaller to keep elaboration light.

Top module: `plc_page_load`

## Requirements
- R1: After reset, `busy` and `page_err` are 0 and `dout` is 0.
- R2: A byte load needs `ce_n` = 0, `we_n` = 0 and `oe_n` = 1 together. With `oe_n` held low during the strobes, no page opens (`busy` stays 0) and the array keeps its old byte.
- R3: The stored address is the `addr` value present when the later of the `ce_n`/`we_n` falling edges completes the load condition.
- R4: The stored data is the `din` value present when the earlier of the `ce_n`/`we_n` rising edges ends the load condition. Later changes to `din` are not stored.
- R5: One page holds 128 bytes. `addr[ADDR_W-1:7]` selects the page and `addr[6:0]` selects the byte. All 128 bytes of a page can be loaded in one page and are all stored.
- R6: Each load start restarts the byte-load window. A page stays open (`busy` = 0) for as long as the loads keep coming within `WIN_CYC` cycles of each other, whatever the total length of the page.
- R7: When `WIN_CYC` cycles pass after the last load start with no new start, the page closes and `busy` rises.
- R8: `busy` stays high for exactly `PROG_CYC` cycles and then falls by itself. After that, reads return the committed bytes.
- R9: Load cycles that begin while `busy` is high are ignored. They store nothing and do not open a new page.
- R10: A load inside an open page with different page bits is stored at its byte offset in the page latched first. It also sets `page_err`, which stays set until reset.
- R11: Only bytes loaded during the page are written to the array. Other bytes of that page keep their old contents.
- R12: A read (`ce_n` = 0, `oe_n` = 0) drives the array byte at `addr` on `dout`. Without a read, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Byte address; upper bits select the page |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when no read is active |
| busy | output | 1 | High during the programming interval |
| page_err | output | 1 | Sticky flag for a load whose page bits differ from the open page |

## Verification
Each strobe edge takes three clock edges to be recognised, so `dout` follows a read strobe three cycles later. `busy` rises `WIN_CYC` plus about four cycles after the last load start, and then stays up for exactly `PROG_CYC` cycles. The bench drives everything on falling clock edges. It samples only at points that sit several cycles clear of these instants: `busy` low well before the window can expire, high well after it must have expired, and low again after the programming span. Array contents are checked only after a page has finished programming, by reads that hold the strobes five cycles before sampling.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ld_state_t;
endpackage

// File: rtl/plc_strobe_sync.sv
module plc_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic ld_start,
  output logic ld_end,
  output logic rd_en
);
  // bit 2: chip select, bit 1: write strobe, bit 0: read strobe
  logic [2:0] meta_q, sync_q;
  logic       wr_q;
  logic       wr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 3'b111;
      sync_q <= 3'b111;
      wr_q   <= 1'b0;
    end else begin
      meta_q <= {ce_n, we_n, oe_n};
      sync_q <= meta_q;
      wr_q   <= wr_now;
    end
  end

  assign wr_now   = ~sync_q[2] & ~sync_q[1] & sync_q[0];
  assign ld_start = wr_now & ~wr_q;   // later falling edge completes the condition
  assign ld_end   = ~wr_now & wr_q;   // earlier rising edge ends it
  assign rd_en    = ~sync_q[2] & ~sync_q[0];
endmodule

// File: rtl/plc_page_buf.sv
module plc_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int SLOTS = 1 << OFF_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr)        vld_d = '0;
    else if (wr_en) vld_d[wr_off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_off] <= wr_data;
  end

  assign rd_data  = slot_q[rd_off];
  assign rd_valid = vld_q[rd_off];
endmodule

// File: rtl/plc_array.sv
module plc_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
    rdata <= cell_q[raddr];
  end
endmodule

// File: rtl/plc_page_load.sv
module plc_page_load #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 7,
  parameter int WIN_CYC  = 5000,
  parameter int PROG_CYC = 150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              busy,
  output logic              page_err
);
  import plc_pkg::*;

  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int WIN_W      = $clog2(WIN_CYC + 1);
  localparam int PRG_W      = $clog2(PROG_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);
  localparam logic [PRG_W-1:0] PRG_COPY = PRG_W'(PAGE_BYTES);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic ld_start, ld_end, rd_en;

  plc_strobe_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .ld_start (ld_start),
    .ld_end   (ld_end),
    .rd_en    (rd_en)
  );

  ld_state_t         state_q, state_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [PRG_W-1:0]  prg_q, prg_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              armed_q, armed_d;
  logic              err_q, err_d;
  logic              buf_clr;

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    prg_d   = prg_q;
    page_d  = page_q;
    off_d   = off_q;
    armed_d = armed_q;
    err_d   = err_q;
    buf_clr = 1'b0;
    if (ld_end) armed_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ld_start) begin
          state_d = ST_LOAD;
          page_d  = addr[ADDR_W-1:OFF_W];
          off_d   = addr[OFF_W-1:0];
          armed_d = 1'b1;
          win_d   = '0;
        end
      end
      ST_LOAD: begin
        if (ld_start) begin
          off_d   = addr[OFF_W-1:0];
          armed_d = 1'b1;
          win_d   = '0;
          if (addr[ADDR_W-1:OFF_W] != page_q) err_d = 1'b1;
        end else if (win_q == WIN_LAST) begin
          if (!armed_q) begin
            state_d = ST_PROG;
            prg_d   = '0;
          end
        end else begin
          win_d = win_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (prg_q == PRG_LAST) begin
          state_d = ST_IDLE;
          buf_clr = 1'b1;
        end else begin
          prg_d = prg_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      prg_q   <= '0;
      page_q  <= '0;
      off_q   <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      prg_q   <= prg_d;
      page_q  <= page_d;
      off_q   <= off_d;
      armed_q <= armed_d;
      err_q   <= err_d;
    end
  end

  // staging buffer and copy-out during programming
  logic              buf_we;
  logic [DATA_W-1:0] buf_rdata;
  logic              buf_rvalid;
  logic              copy_live;
  logic              arr_we;
  logic [DATA_W-1:0] arr_rdata;

  assign buf_we    = ld_end & armed_q;
  assign copy_live = (state_q == ST_PROG) && (prg_q < PRG_COPY);
  assign arr_we    = copy_live & buf_rvalid;

  plc_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (buf_we),
    .wr_off   (off_q),
    .wr_data  (din),
    .clr      (buf_clr),
    .rd_off   (prg_q[OFF_W-1:0]),
    .rd_data  (buf_rdata),
    .rd_valid (buf_rvalid)
  );

  plc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr ({page_q, prg_q[OFF_W-1:0]}),
    .wdata (buf_rdata),
    .raddr (addr),
    .rdata (arr_rdata)
  );

  logic rd_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_q <= 1'b0;
    else             rd_q <= rd_en;
  end

  assign dout     = rd_q ? arr_rdata : '0;
  assign busy     = (state_q == ST_PROG);
  assign page_err = err_q;
endmodule

// File: rtl/plc_page_load_chk.sv
module plc_page_load_chk #(
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 150000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              busy,
  input logic              page_err,
  input logic [DATA_W-1:0] dout
);
  logic [31:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 32'd1;
    else           busy_run_q <= '0;
  end

  // R8: the programming span is exactly PROG_CYC cycles
  p_busy_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run_q == 32'(PROG_CYC)));

  // R8: busy never outlasts the programming span
  p_busy_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run_q <= 32'(PROG_CYC));

  // R10: the page mismatch flag holds once set
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  // R7: a page closes only while no write strobe is held
  p_close_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(we_n));

  // R12: no read select three cycles back means a quiet output
  p_read_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n, 3) |-> (dout == '0));
endmodule

bind plc_page_load plc_page_load_chk #(.DATA_W(DATA_W), .PROG_CYC(PROG_CYC)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .we_n     (we_n),
  .busy     (busy),
  .page_err (page_err),
  .dout     (dout)
);

// File: tb/test_plc_page_load.sv
module test_plc_page_load;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 8;
  localparam int OFF_W    = 7;
  localparam int PAGE_W   = ADDR_W - OFF_W;
  localparam int WIN_CYC  = 40;
  localparam int PROG_CYC = 200;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n, we_n, oe_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] dout;
  logic              busy, page_err;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // bench model
  logic [DATA_W-1:0] mdl  [1 << ADDR_W];
  bit                mval [1 << ADDR_W];
  logic [DATA_W-1:0] pend [1 << OFF_W];
  bit                pv   [1 << OFF_W];
  logic [PAGE_W-1:0] ppage;
  bit                popen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plc_page_load #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
    .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
  ) i_plc_page_load (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .page_err(page_err)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int pg, input int off);
    return ADDR_W'((pg << OFF_W) | off);
  endfunction

  task automatic drive_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit oe_low);
    addr = a; din = d; oe_n = !oe_low;
    cyc(1);
    ce_n = 1'b0; we_n = 1'b0;
    cyc(4);
    we_n = 1'b1;
    cyc(2);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(3);
  endtask

  task automatic note_load(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    if (!popen) begin
      popen = 1;
      ppage = a[ADDR_W-1:OFF_W];
    end
    pend[a[OFF_W-1:0]] = d;
    pv[a[OFF_W-1:0]]   = 1;
  endtask

  // WE-controlled load; page must remain open afterwards (R6)
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    note_load(a, d);
    drive_wr(a, d, 0);
    check("R6 page held open", busy, 0);
  endtask

  // CE-controlled load with address moved before the later edge and data moved after the earlier edge
  task automatic wr_ce(input logic [ADDR_W-1:0] a_bad, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] d_bad);
    note_load(a, d);
    addr = a_bad; din = d; oe_n = 1'b1;
    we_n = 1'b0;
    cyc(4);
    addr = a;
    cyc(1);
    ce_n = 1'b0;
    cyc(5);
    ce_n = 1'b1;
    cyc(4);
    din = d_bad; addr = a_bad;
    cyc(2);
    we_n = 1'b1;
    cyc(3);
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    cyc(5);
    check(tag, dout, mdl[a]);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(3);
  endtask

  // wait for window expiry and programming; optionally try a load while busy
  task automatic close_page(input string rd_tag, input bit intrude,
                            input logic [ADDR_W-1:0] ia, input logic [DATA_W-1:0] id);
    logic [ADDR_W-1:0] a;
    cyc(WIN_CYC + 6);
    check("R7 busy after idle window", busy, 1);
    if (intrude) begin
      drive_wr(ia, id, 0);
      cyc(PROG_CYC - 11);
    end else begin
      cyc(PROG_CYC);
    end
    check("R8 busy ends", busy, 0);
    for (int o = 0; o < (1 << OFF_W); o++) begin
      if (pv[o]) begin
        a = {ppage, OFF_W'(o)};
        mdl[a]  = pend[o];
        mval[a] = 1;
      end
    end
    for (int o = 0; o < (1 << OFF_W); o++) begin
      if (pv[o]) rd_chk(rd_tag, {ppage, OFF_W'(o)});
      pv[o] = 0;
    end
    popen = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] ra;
    int pg, n;
    void'($urandom(32'd7321));
    for (int i = 0; i < (1 << OFF_W); i++) pv[i] = 0;
    for (int i = 0; i < (1 << ADDR_W); i++) mval[i] = 0;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    check("R1 busy after reset", busy, 0);
    check("R1 page_err after reset", page_err, 0);
    check("R1 dout after reset", dout, 0);

    // R2: normal byte, then an inhibited attempt with the read strobe low
    wr(mk(0, 16), 8'h5A);
    close_page("R2 base byte", 0, '0, '0);
    drive_wr(mk(0, 16), 8'hA5, 1);
    cyc(WIN_CYC + 10);
    check("R2 inhibited load opens no page", busy, 0);
    rd_chk("R2 inhibited byte unchanged", mk(0, 16));

    // R3 and R4: address at the later falling edge, data at the earlier rising edge
    wr_ce(mk(7, 112), mk(2, 35), 8'hC3, 8'h3C);
    close_page("R3 R4 ce-controlled byte", 0, '0, '0);

    // R5: a full page of 128 bytes
    for (int o = 0; o < 128; o++) wr(mk(3, o), DATA_W'(o ^ 8'h3C));
    close_page("R5 full page byte", 0, '0, '0);

    // R11: partial page over old contents
    wr(mk(3, 3), 8'hE1);
    wr(mk(3, 5), 8'hE2);
    close_page("R11 loaded byte", 0, '0, '0);
    rd_chk("R11 untouched neighbour", mk(3, 4));
    rd_chk("R11 untouched byte", mk(3, 100));

    // R9: a load arriving during programming
    wr(mk(4, 80), 8'h11);
    wr(mk(4, 81), 8'h12);
    close_page("R9 page byte", 1, mk(4, 80), 8'hEE);
    rd_chk("R9 ignored load left byte", mk(4, 80));
    cyc(WIN_CYC + 10);
    check("R9 ignored load opened no page", busy, 0);

    // R10: mismatched page bits land in the latched page
    wr(mk(6, 9), 8'h42);
    close_page("R10 setup byte", 0, '0, '0);
    check("R10 flag clear before mismatch", page_err, 0);
    wr(mk(5, 1), 8'h21);
    wr(mk(5, 2), 8'h22);
    note_load(mk(5, 9), 8'h77);
    drive_wr(mk(6, 9), 8'h77, 0);
    check("R10 flag set", page_err, 1);
    close_page("R10 redirected byte", 0, '0, '0);
    rd_chk("R10 other page unchanged", mk(6, 9));

    // random pages (R5 R6 R8 R12)
    for (int r = 0; r < 5; r++) begin
      pg = $urandom_range((1 << PAGE_W) - 1, 0);
      n  = $urandom_range(12, 1);
      for (int k = 0; k < n; k++) begin
        ra = mk(pg, $urandom_range(127, 0));
        wr(ra, DATA_W'($urandom));
      end
      close_page("R12 random readback", 0, '0, '0);
    end
    check("R10 flag still set", page_err, 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule